// File: doc/BRIEF.md
# Serial FPGA Configuration Streamer

This block loads a target FPGA through a bit-serial configuration port. The port has three lines: an active-low program line, a configuration clock and a serial data line. A single `start` pulse sets off a fixed preparation sequence. The block first raises a power-enable output and waits for the supply to settle. It then holds a quiet setup interval with the program line high and the clock and data lines low. Next it drives the program line low for a long clearing pulse and releases it.

After the program line is released, the block pulls 32-bit words from a valid/ready stream. The number of words is latched at start. Each word is sent as four bytes, and every byte goes out most significant bit first, one clock pulse per bit. A byte-order input, also latched at start, chooses whether the least or the most significant byte of each word leaves first. `busy` covers the whole sequence. A one-cycle `done` marks its end, and the block then returns to idle.

All delays are counted in system clock cycles and set by parameters: settle, setup, program-pulse length and the width of each clock phase.

Top module: `cfg_stream_loader`

## Requirements
- R1: Out of reset: `pwr_en`=0, `prog_n`=1, `cclk`=0, `din`=0, `busy`=0, `done`=0, `s_ready`=0.
- R2: `start` in idle is taken at a clock edge. From that edge `busy` and `pwr_en` are 1. Once raised, `pwr_en` stays 1 until reset.
- R3: `prog_n` falls exactly SETTLE_CYC+SETUP_CYC cycles after the start edge. Until then `cclk` and `din` stay 0, and `prog_n` is low only while `pwr_en` is 1.
- R4: `prog_n` stays low for exactly PROG_CYC cycles and then returns high. `cclk` does not rise while `prog_n` is low.
- R5: `s_ready` is 1 only after the program pulse, while the block waits for a word with `cclk` low. A word is taken on a cycle where both `s_valid` and `s_ready` are 1.
- R6: Each word gives exactly 32 rising edges of `cclk`. `din` is set while `cclk` is low and held across the rise. Within each byte, bit 7 goes first and bit 0 last.
- R7: With `byte_swap`=0, bytes go out in the order bits [7:0], [15:8], [23:16], [31:24]. With `byte_swap`=1 the order is [31:24], [23:16], [15:8], [7:0].
- R8: Each `cclk` high phase lasts exactly HALF_CYC cycles. Each low phase before a rise lasts at least HALF_CYC cycles.
- R9: After the last bit of the `word_count`-th word, `done` is 1 for exactly one cycle, with `busy`=0 and `cclk`=0 in that cycle. The block then stays idle. Exactly `word_count` words are accepted.
- R10: With `word_count`=0, `done` follows the program pulse. No word is accepted and `cclk` never rises.
- R11: `start` while `busy` is ignored: the run ends with exactly one `done`, and no new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load sequence (taken only when idle) |
| word_count | input | LEN_W | Number of 32-bit words to send, latched at start |
| byte_swap | input | 1 | 0: low byte first, 1: high byte first; latched at start |
| s_valid | input | 1 | Stream word available |
| s_data | input | WORD_W | Stream word |
| s_ready | output | 1 | Block accepts a word this cycle |
| pwr_en | output | 1 | Target power enable |
| prog_n | output | 1 | Active-low clear line to the target |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the byte order in both settings, using words whose bytes differ so that a reversed lane or a byte sent LSB first shows up as a bit mismatch. A shifter that drops or repeats a bit at a word boundary gives the wrong number of clock rises. It measures the exact cycle distances of the program pulse, so an off-by-one in any delay counter moves the fall or changes the pulse length. A zero word count and a `start` pulse during a run are also applied. A design that waits for data forever, shifts one word, or restarts its sequence would give a missing or duplicated `done`. Random gaps on `s_valid` test that a stalled stream holds the clock low rather than shifting stale data.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SETUP  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_FETCH  = 3'd4,
    ST_SHIFT  = 3'd5,
    ST_DONE   = 3'd6
  } ld_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Which byte lane of a word is sent in transmit slot 'slot' (slot 0 first).
  function automatic int unsigned lane_of_slot(input int unsigned slot, input logic swap,
                                               input int unsigned nbytes);
    return swap ? (nbytes - 1 - slot) : slot;
  endfunction

endpackage

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter
  import cfg_stream_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              swap,
  output logic              cclk_o,
  output logic              din_o,
  output logic              word_end
);

  localparam int unsigned BYTES = WORD_W / 8;
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam int unsigned PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYC - 1);

  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic [PH_W-1:0]   ph;
  logic              hi;
  logic              active;
  logic              ph_end;

  // Arrange the word so the first bit to send sits at the top.
  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    localparam int unsigned LN_NORM = lane_of_slot(g, 1'b0, BYTES);
    localparam int unsigned LN_SWAP = lane_of_slot(g, 1'b1, BYTES);
    assign ordered[WORD_W-1-8*g -: 8] = swap ? word[8*LN_SWAP +: 8] : word[8*LN_NORM +: 8];
  end

  assign ph_end = (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      idx    <= '0;
      ph     <= '0;
      hi     <= 1'b0;
      active <= 1'b0;
    end else if (clr) begin
      shreg  <= '0;
      idx    <= '0;
      ph     <= '0;
      hi     <= 1'b0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= ordered;
      idx    <= '0;
      ph     <= '0;
      hi     <= 1'b0;
      active <= 1'b1;
    end else if (active) begin
      if (ph_end) begin
        ph <= '0;
        if (!hi) begin
          hi <= 1'b1;
        end else begin
          hi    <= 1'b0;
          shreg <= {shreg[WORD_W-2:0], 1'b0};
          idx   <= idx + 1'b1;
          if (idx == LAST_IDX) active <= 1'b0;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign cclk_o   = hi;
  assign din_o    = shreg[WORD_W-1];
  assign word_end = active && hi && ph_end && (idx == LAST_IDX);

  // R6: data is steady across every rising clock edge
  a_r6_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));

  // R6: data only moves while the clock is low
  a_r6_din_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din_o) |-> !cclk_o);

  // R5: a new word is never loaded in the middle of a high phase
  a_r5_load_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !cclk_o);

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_stream_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 64,
  parameter int unsigned SETUP_CYC  = 16,
  parameter int unsigned PROG_CYC   = 32,
  parameter int unsigned HALF_CYC   = 2,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  word_count,
  input  logic              byte_swap,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              pwr_en,
  output logic              prog_n,
  output logic              cclk,
  output logic              din,
  output logic              busy,
  output logic              done
);

  localparam int unsigned TMR_W = $clog2(max3(SETTLE_CYC, SETUP_CYC, PROG_CYC) + 1);

  ld_state_e        state, state_nx;
  logic [LEN_W-1:0] words_left;
  logic             swap_q;
  logic             pwr_q;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;

  // named events
  logic start_accept, settle_over, setup_over, pulse_over;
  logic word_take, word_end, last_word;

  assign start_accept = (state == ST_IDLE)   && start;
  assign settle_over  = (state == ST_SETTLE) && tmr_zero;
  assign setup_over   = (state == ST_SETUP)  && tmr_zero;
  assign pulse_over   = (state == ST_PULSE)  && tmr_zero;
  assign word_take    = (state == ST_FETCH)  && s_valid;
  assign last_word    = (words_left == LEN_W'(1));

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    if (start_accept)      tmr_val = TMR_W'(SETTLE_CYC - 1);
    else if (settle_over)  tmr_val = TMR_W'(SETUP_CYC - 1);
    else if (setup_over)   tmr_val = TMR_W'(PROG_CYC - 1);
    else                   tmr_load = 1'b0;
  end

  cfg_delay_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  cfg_bit_shifter #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_accept),
    .load     (word_take),
    .word     (s_data),
    .swap     (swap_q),
    .cclk_o   (cclk),
    .din_o    (din),
    .word_end (word_end)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start) state_nx = ST_SETTLE;
      ST_SETTLE: if (tmr_zero) state_nx = ST_SETUP;
      ST_SETUP:  if (tmr_zero) state_nx = ST_PULSE;
      ST_PULSE:  if (tmr_zero) state_nx = (words_left == '0) ? ST_DONE : ST_FETCH;
      ST_FETCH:  if (s_valid) state_nx = ST_SHIFT;
      ST_SHIFT:  if (word_end) state_nx = last_word ? ST_DONE : ST_FETCH;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      words_left <= '0;
      swap_q     <= 1'b0;
      pwr_q      <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_accept) begin
        words_left <= word_count;
        swap_q     <= byte_swap;
        pwr_q      <= 1'b1;
      end else if ((state == ST_SHIFT) && word_end) begin
        words_left <= words_left - 1'b1;
      end
    end
  end

  assign pwr_en  = pwr_q;
  assign prog_n  = (state != ST_PULSE);
  assign s_ready = (state == ST_FETCH);
  assign busy    = (state != ST_IDLE) && (state != ST_DONE);
  assign done    = (state == ST_DONE);

  // R3: the target is only cleared with power applied
  a_r3_prog_with_power: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> pwr_en);

  // R2: power enable never drops once raised
  a_r2_power_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> 1'b0);

  // R4: no configuration clock during the clearing pulse
  a_r4_no_clock_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |-> prog_n);

  // R5: the stream is offered only with the clock low
  a_r5_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cclk);

  // R9: done is a single-cycle pulse, never together with busy
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, busy}));

  // R10: waiting for a word implies at least one word is still owed
  a_r10_fetch_owed: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (words_left != '0));

endmodule

// File: tb/sim_cfg_stream_loader.sv
module sim_cfg_stream_loader;

  localparam int SETTLE = 20;
  localparam int SETUP  = 6;
  localparam int PROG   = 12;
  localparam int HALF   = 2;
  localparam int MAXW   = 8;
  localparam int MAXB   = 32 * MAXW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] word_count = '0;
  logic        byte_swap = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, pwr_en, prog_n, cclk, din, busy, done;

  always #5 clk = ~clk;

  cfg_stream_loader #(
    .SETTLE_CYC(SETTLE), .SETUP_CYC(SETUP), .PROG_CYC(PROG),
    .HALF_CYC(HALF), .WORD_W(32), .LEN_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .byte_swap(byte_swap), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .pwr_en(pwr_en), .prog_n(prog_n), .cclk(cclk), .din(din), .busy(busy), .done(done)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected bit k of a run, computed from R6/R7
  logic [31:0] wbuf [MAXW];
  function automatic logic exp_bit(input int k, input logic swp);
    int w, p, slot, lane, b;
    w    = k / 32;
    p    = k % 32;
    slot = p / 8;
    lane = swp ? 3 - slot : slot;
    b    = 7 - (p % 8);
    return wbuf[w][lane*8 + b];
  endfunction

  // monitor / feeder state
  int  cyc = 0;
  logic got [MAXB];
  int  nb, seen_busy, t_busy, seen_prog, t_prog, prog_low, early_clk, pre_bad;
  int  hi_len, low_len, hi_bad, low_bad, done_cnt = 0, done_bad, accepted;
  int  feed_n, feed_idx;
  bit  pend, feed_en = 0;
  logic prev_cclk = 1'b0;

  task automatic clear_mon();
    nb = 0; seen_busy = 0; seen_prog = 0; prog_low = 0; early_clk = 0; pre_bad = 0;
    hi_len = 0; low_len = 1000; hi_bad = 0; low_bad = 0; done_bad = 0;
    accepted = 0; feed_idx = 0; pend = 0; t_busy = 0; t_prog = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && seen_busy == 0) begin seen_busy = 1; t_busy = cyc; end
      if (!prog_n) begin
        if (seen_prog == 0) begin seen_prog = 1; t_prog = cyc; end
        prog_low++;
        if (cclk) early_clk++;
      end
      if (seen_busy != 0 && seen_prog == 0 && (cclk || din)) pre_bad++;
      if (cclk) begin
        if (!prev_cclk) begin
          if (nb < MAXB) got[nb] = din;
          nb++;
          if (low_len < HALF) low_bad++;
        end
        hi_len++;
        low_len = 0;
      end else begin
        if (prev_cclk) begin
          if (hi_len != HALF) hi_bad++;
          hi_len = 0;
        end
        low_len++;
      end
      if (done) begin
        done_cnt++;
        if (busy || cclk) done_bad++;
      end
      if (feed_en) begin
        if (pend) begin accepted++; feed_idx++; end
        if (feed_idx < feed_n && ($urandom % 4) != 0) begin
          s_valid = 1'b1;
          s_data  = wbuf[feed_idx];
        end else begin
          s_valid = 1'b0;
          s_data  = $urandom;
        end
        pend = s_valid && s_ready;
      end
    end
    prev_cclk = cclk;
  end

  task automatic run(input int n, input logic swp, input bit poke, input string name);
    int d0, guard, bad_bits;
    clear_mon();
    feed_n = n;
    feed_en = 1;
    d0 = done_cnt;
    @(negedge clk); #1;
    word_count = 16'(n);
    byte_swap  = swp;
    start      = 1'b1;
    @(negedge clk); #1;
    start      = 1'b0;
    byte_swap  = ~swp;
    word_count = 16'(n + 3);
    chk(busy === 1'b1 && pwr_en === 1'b1, {name, " R2 busy/pwr after start"},
        {busy, pwr_en}, 3);
    guard = 0;
    while (done_cnt == d0 && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      if (poke && guard == 150) start = 1'b1;
      if (poke && guard == 151) start = 1'b0;
    end
    chk(guard < 20000, {name, " R9 done reached"}, guard, 0);
    chk(t_prog - t_busy == SETTLE + SETUP, {name, " R3 prog fall delay"},
        t_prog - t_busy, SETTLE + SETUP);
    chk(pre_bad == 0, {name, " R3 cclk/din low before pulse"}, pre_bad, 0);
    chk(prog_low == PROG && early_clk == 0, {name, " R4 pulse length"}, prog_low, PROG);
    chk(nb == 32 * n, {name, " R6 clock rises"}, nb, 32 * n);
    chk(hi_bad == 0 && low_bad == 0, {name, " R8 phase widths"}, hi_bad + low_bad, 0);
    for (int w = 0; w < n; w++) begin
      bad_bits = 0;
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < nb && got[w*32+b] !== exp_bit(w * 32 + b, swp)) bad_bits++;
      chk(bad_bits == 0, {name, swp ? " R7 swapped order" : " R7 normal order"},
          bad_bits, 0);
    end
    chk(done_bad == 0, {name, " R9 done with busy/cclk low"}, done_bad, 0);
    repeat (12) @(negedge clk);
    #1;
    feed_en = 0;
    s_valid = 1'b0;
    chk(accepted == n, {name, n == 0 ? " R10 no word taken" : " R9 words taken"}, accepted, n);
    chk(done_cnt == d0 + 1 && busy === 1'b0, {name, poke ? " R11 one done only" : " R9 single done"},
        done_cnt - d0, 1);
    chk(pwr_en === 1'b1, {name, " R2 power held"}, pwr_en, 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(pwr_en === 0 && prog_n === 1 && cclk === 0 && din === 0 && busy === 0 &&
        done === 0 && s_ready === 0, "R1 reset outputs",
        {pwr_en, prog_n, cclk, din, busy, done, s_ready}, 7'b0100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wbuf[0] = 32'h81_3C_F0_0F;
    run(1, 1'b0, 0, "directed normal");
    wbuf[0] = 32'h81_3C_F0_0F;
    run(1, 1'b1, 0, "directed swapped");
    run(0, 1'b0, 0, "R10 zero words");
    for (int r = 0; r < 5; r++) begin
      int n;
      n = 2 + int'($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = $urandom;
      run(n, 1'($urandom % 2), 0, "random");
    end
    for (int i = 0; i < 3; i++) wbuf[i] = $urandom;
    run(3, 1'b1, 1, "R11 restart poke");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule